// File: doc/BRIEF.md
# Programmable Peripheral Interrupt Router

The router collects a bank of peripheral interrupt request lines and spreads them over seven core priority levels. Each source carries a 4-bit routing field that names the level it belongs to. Every source that is both requesting and enabled in the mask raises its level's line. For each level the router also reports which source should be serviced: the lowest-numbered enabled, requesting source routed to that level.

Software programs the router through a small word-addressed register bus. The bus holds the routing words, the enable mask, a wake-enable word, a read-only view of the synchronized requests, and a read-only saturating count of spurious acknowledges. The router keeps no latch of its own on the requests. A source stays pending for as long as its peripheral holds the line, and clearing is done at the peripheral. When the core acknowledges a level that has no enabled pending source, the router flags a spurious event.

Top module: `irq_router`

## Requirements
- R1: Source n's routing field sits at bits [(n%8)*4 +: 4] of the routing word at bus word address n/8 (addresses 0 to 3 for 32 sources). After reset, field n holds n mod 7.
- R2: A field value v in 0..6 routes the source to `lvl_irq[v]`, where bit 0 is the lowest core level. Field values 7 to 15 route the source to no level.
- R3: The effective pending set is the synchronized request ANDed with the mask word at address 4. A mask bit of 1 enables its source. The mask resets to all zeros, and all ones written to it enables every source.
- R4: Within a level, the lowest-indexed effective pending source wins. Its index is reported on `win_id[l*5 +: 5]`. A level with no winner drives `lvl_irq[l]`=0 and ID 0.
- R5: A change on `irq_in` reaches `lvl_irq`/`win_id` two clock edges later. A register write changes them one edge after the write edge.
- R6: A read of address 6 returns the synchronized requests, bit n for source n. Writes to addresses 6 and 7 change nothing.
- R7: `wake_req` is high when any synchronized request has its wake-enable bit set. The wake-enable word is at address 5 and resets to zero. The mask does not affect `wake_req`, which has the same latency as R5.
- R8: When `ack_vld` is high and `ack_lvl` names a level whose `lvl_irq` bit is low, `spur_pulse` is high for the next cycle and the spurious count rises by one. Acknowledging an active level, or a value of `ack_lvl` of 7 or more, does neither.
- R9: The spurious count is read at address 7. It stops at 2^SPUR_W-1 (255 by default) and resets to 0.
- R10: `bus_rdata` is loaded on the edge where `bus_rd` is high. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_in | input | NUM_SRC | Raw peripheral request levels |
| lvl_irq | output | NUM_LVL | Per-level request lines |
| win_id | output | NUM_LVL*IDX_W | Per-level winning source index |
| wake_req | output | 1 | Wake request |
| ack_vld | input | 1 | Core acknowledges a level |
| ack_lvl | input | LVL_W | Level being acknowledged |
| spur_pulse | output | 1 | Spurious acknowledge flag |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never driven with unknown values. They also assume that `ack_lvl` only matters while `ack_vld` is high, and that the mask and wake words change only through the bus. The stimulus changes every input half a cycle away from the active edge. It drives `ack_lvl` both inside and beyond the seven levels, and it uses random routing words whose fields include unrouted values. Spurious acknowledges are issued in long runs so that the counter reaches and holds its ceiling.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int FIELD_W   = 4;
  localparam int WORD_W    = 32;
  localparam int FLD_PER_W = WORD_W / FIELD_W;

  // default routing: source n goes to level n mod number of levels
  function automatic logic [WORD_W-1:0] default_route_word(input int word, input int num_lvl);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < FLD_PER_W; k++)
      w[k*FIELD_W +: FIELD_W] = FIELD_W'((word*FLD_PER_W + k) % num_lvl);
    return w;
  endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 7,
  parameter int ADDR_W  = 4,
  parameter int SPUR_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [WORD_W-1:0]          wdata,
  input  logic [NUM_SRC-1:0]         status,
  input  logic [SPUR_W-1:0]          spur_cnt,
  output logic [WORD_W-1:0]          rdata,
  output logic [NUM_SRC*FIELD_W-1:0] route_flat,
  output logic [NUM_SRC-1:0]         mask,
  output logic [NUM_SRC-1:0]         wake
);
  localparam int N_RTE     = (NUM_SRC + FLD_PER_W - 1) / FLD_PER_W;
  localparam int N_BANK    = (NUM_SRC + WORD_W - 1) / WORD_W;
  localparam int MASK_BASE = N_RTE;
  localparam int WAKE_BASE = N_RTE + N_BANK;
  localparam int STAT_BASE = N_RTE + 2*N_BANK;
  localparam int SPUR_ADDR = N_RTE + 3*N_BANK;
  localparam int PAD_W     = N_BANK*WORD_W;

  logic [WORD_W-1:0] rte_q  [N_RTE];
  logic [WORD_W-1:0] mask_q [N_BANK];
  logic [WORD_W-1:0] wake_q [N_BANK];
  logic [PAD_W-1:0]  stat_pad;
  logic [WORD_W-1:0] rd_mux;

  assign stat_pad = PAD_W'(status);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < N_RTE; w++) rte_q[w] <= default_route_word(w, NUM_LVL);
      for (int b = 0; b < N_BANK; b++) begin
        mask_q[b] <= '0;
        wake_q[b] <= '0;
      end
    end else if (wr_en) begin
      for (int w = 0; w < N_RTE; w++)
        if (addr == ADDR_W'(w)) rte_q[w] <= wdata;
      for (int b = 0; b < N_BANK; b++) begin
        if (addr == ADDR_W'(MASK_BASE + b)) mask_q[b] <= wdata;
        if (addr == ADDR_W'(WAKE_BASE + b)) wake_q[b] <= wdata;
      end
    end
  end

  generate
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_flat
      assign route_flat[n*FIELD_W +: FIELD_W] =
        rte_q[n/FLD_PER_W][(n%FLD_PER_W)*FIELD_W +: FIELD_W];
      assign mask[n] = mask_q[n/WORD_W][n%WORD_W];
      assign wake[n] = wake_q[n/WORD_W][n%WORD_W];
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < N_RTE; w++)
      if (addr == ADDR_W'(w)) rd_mux = rte_q[w];
    for (int b = 0; b < N_BANK; b++) begin
      if (addr == ADDR_W'(MASK_BASE + b)) rd_mux = mask_q[b];
      if (addr == ADDR_W'(WAKE_BASE + b)) rd_mux = wake_q[b];
      if (addr == ADDR_W'(STAT_BASE + b)) rd_mux = stat_pad[b*WORD_W +: WORD_W];
    end
    if (addr == ADDR_W'(SPUR_ADDR)) rd_mux = WORD_W'(spur_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_level_pick.sv
module irq_level_pick
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int LVL_ID  = 0,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0]         eff,
  input  logic [NUM_SRC*FIELD_W-1:0] route_flat,
  output logic                       hit,
  output logic [IDX_W-1:0]           win
);
  // scan downward so the last match kept is the lowest index
  always_comb begin
    hit = 1'b0;
    win = '0;
    for (int i = NUM_SRC-1; i >= 0; i--) begin
      if (eff[i] && route_flat[i*FIELD_W +: FIELD_W] == FIELD_W'(LVL_ID)) begin
        hit = 1'b1;
        win = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_spur_count.sv
module irq_spur_count #(
  parameter int NUM_LVL = 7,
  parameter int LVL_W   = 3,
  parameter int SPUR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ack_vld,
  input  logic [LVL_W-1:0]   ack_lvl,
  input  logic [NUM_LVL-1:0] lvl_act,
  output logic               pulse,
  output logic [SPUR_W-1:0]  cnt
);
  logic in_range;
  logic sel_act;
  logic spur;

  always_comb begin
    in_range = 1'b0;
    sel_act  = 1'b0;
    for (int l = 0; l < NUM_LVL; l++) begin
      if (ack_lvl == LVL_W'(l)) begin
        in_range = 1'b1;
        sel_act  = lvl_act[l];
      end
    end
  end

  assign spur = ack_vld && in_range && !sel_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse <= 1'b0;
      cnt   <= '0;
    end else begin
      pulse <= spur;
      if (spur && cnt != {SPUR_W{1'b1}}) cnt <= cnt + SPUR_W'(1);
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 7,
  parameter int ADDR_W  = 4,
  parameter int SPUR_W  = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int LVL_W  = $clog2(NUM_LVL + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NUM_SRC-1:0]       irq_in,
  output logic [NUM_LVL-1:0]       lvl_irq,
  output logic [NUM_LVL*IDX_W-1:0] win_id,
  output logic                     wake_req,
  input  logic                     ack_vld,
  input  logic [LVL_W-1:0]         ack_lvl,
  output logic                     spur_pulse
);
  logic [NUM_SRC-1:0]         stat_q;
  logic [NUM_SRC-1:0]         mask_w;
  logic [NUM_SRC-1:0]         wake_w;
  logic [NUM_SRC-1:0]         eff;
  logic [NUM_SRC*FIELD_W-1:0] route_w;
  logic [SPUR_W-1:0]          spur_cnt_w;
  logic [NUM_LVL-1:0]         hit_w;
  logic [NUM_LVL*IDX_W-1:0]   win_w;

  irq_regfile #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .ADDR_W(ADDR_W), .SPUR_W(SPUR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .status(stat_q), .spur_cnt(spur_cnt_w), .rdata(bus_rdata),
    .route_flat(route_w), .mask(mask_w), .wake(wake_w)
  );

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= irq_in;
  end

  assign eff = stat_q & mask_w;

  generate
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
      irq_level_pick #(.NUM_SRC(NUM_SRC), .LVL_ID(l), .IDX_W(IDX_W)) u_pick (
        .eff(eff), .route_flat(route_w),
        .hit(hit_w[l]), .win(win_w[l*IDX_W +: IDX_W])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_irq  <= '0;
      win_id   <= '0;
      wake_req <= 1'b0;
    end else begin
      lvl_irq  <= hit_w;
      win_id   <= win_w;
      wake_req <= |(stat_q & wake_w);
    end
  end

  irq_spur_count #(.NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .SPUR_W(SPUR_W)) u_spur (
    .clk(clk), .rst(rst), .ack_vld(ack_vld), .ack_lvl(ack_lvl),
    .lvl_act(lvl_irq), .pulse(spur_pulse), .cnt(spur_cnt_w)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NUM_SRC = 32,
  parameter int NUM_LVL = 7,
  parameter int LVL_W   = 3,
  parameter int SPUR_W  = 8
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] stat,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] wake,
  input logic [NUM_LVL-1:0] lvl_irq,
  input logic               wake_req,
  input logic               ack_vld,
  input logic [LVL_W-1:0]   ack_lvl,
  input logic               spur_pulse,
  input logic [SPUR_W-1:0]  cnt
);
  localparam logic [SPUR_W-1:0] CMAX = {SPUR_W{1'b1}};
  logic act_sel;
  assign act_sel = (32'(ack_lvl) < NUM_LVL) && (((lvl_irq >> ack_lvl) & NUM_LVL'(1)) != '0);

  assert_mask_zero_R3: assert property (@(posedge clk) disable iff (rst)
    $past(mask) == '0 |-> lvl_irq == '0);

  assert_wake_zero_R7: assert property (@(posedge clk) disable iff (rst)
    $past(stat & wake) == '0 |-> !wake_req);

  assert_no_spur_active_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && act_sel) |=> !spur_pulse);

  assert_spur_step_R8: assert property (@(posedge clk) disable iff (rst)
    spur_pulse |-> (cnt == $past(cnt) + SPUR_W'(1)) || (cnt == CMAX));

  assert_spur_mono_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> cnt >= $past(cnt));

  assert_spur_sat_R9: assert property (@(posedge clk) disable iff (rst)
    cnt == CMAX |=> cnt == CMAX);
endmodule

bind irq_router irq_router_chk #(.NUM_SRC(NUM_SRC), .NUM_LVL(NUM_LVL), .LVL_W(LVL_W), .SPUR_W(SPUR_W)) chk_i (
  .clk(clk), .rst(rst), .stat(stat_q), .mask(mask_w), .wake(wake_w), .lvl_irq(lvl_irq),
  .wake_req(wake_req), .ack_vld(ack_vld), .ack_lvl(ack_lvl), .spur_pulse(spur_pulse),
  .cnt(spur_cnt_w)
);

// File: tb/irq_router_tb_top.sv
`timescale 1ns/1ps
module irq_router_tb_top;
  localparam int NS = 32;
  localparam int NL = 7;
  localparam int IW = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] irq_in = '0;
  logic [NL-1:0] lvl_irq;
  logic [NL*IW-1:0] win_id;
  logic wake_req;
  logic ack_vld = 1'b0;
  logic [2:0] ack_lvl = '0;
  logic spur_pulse;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0]  m_rte [NS];
  logic [31:0] m_mask = '0;
  logic [31:0] m_wake = '0;
  logic [31:0] rd;
  logic [31:0] ub;

  always #5 clk = ~clk;

  irq_router dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in), .lvl_irq(lvl_irq),
    .win_id(win_id), .wake_req(wake_req), .ack_vld(ack_vld), .ack_lvl(ack_lvl),
    .spur_pulse(spur_pulse)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    if (a < 4)
      for (int k = 0; k < 8; k++) m_rte[a*8+k] = d[k*4 +: 4];
    else if (a == 4) m_mask = d;
    else if (a == 5) m_wake = d;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_word(input int w);
    logic [31:0] x = '0;
    for (int k = 0; k < 8; k++) x[k*4 +: 4] = m_rte[w*8+k];
    return x;
  endfunction

  // expected per-level hit and winner, from R2/R3/R4
  function automatic logic [5:0] exp_pick(input int l);
    for (int i = 0; i < NS; i++)
      if (irq_in[i] && m_mask[i] && m_rte[i] == 4'(l)) return {1'b1, 5'(i)};
    return 6'd0;
  endfunction

  task automatic check_levels(input string req);
    for (int l = 0; l < NL; l++) begin
      logic [5:0] e = exp_pick(l);
      chk(lvl_irq[l] == e[5], req, 32'(lvl_irq[l]), 32'(e[5]));
      chk(win_id[l*IW +: IW] == e[4:0], req, 32'(win_id[l*IW +: IW]), 32'(e[4:0]));
    end
  endtask

  task automatic ack(input logic [2:0] l);
    @(negedge clk);
    ack_vld = 1'b1; ack_lvl = l;
    @(negedge clk);
    ack_vld = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    ub = $urandom(32'h5EED1234);
    for (int n = 0; n < NS; n++) m_rte[n] = 4'(n % NL);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk(lvl_irq == '0, "R3 reset levels", 32'(lvl_irq), 0);
    chk(wake_req == 1'b0, "R7 reset wake", 32'(wake_req), 0);
    chk(spur_pulse == 1'b0, "R8 reset spur", 32'(spur_pulse), 0);
    rdreg(4, rd); chk(rd == 0, "R3 reset mask", rd, 0);
    rdreg(5, rd); chk(rd == 0, "R7 reset wake enable", rd, 0);
    rdreg(7, rd); chk(rd == 0, "R9 reset count", rd, 0);
    for (int w = 0; w < 4; w++) begin
      rdreg(4'(w), rd); chk(rd == exp_word(w), "R1 default routing", rd, exp_word(w));
    end
    rdreg(4'd12, rd); chk(rd == 0, "R10 unmapped read", rd, 0);

    // requests while masked: nothing
    irq_in = 32'h0000_00F0;
    settle();
    check_levels("R3 masked");

    // unmask all
    wr(4, 32'hFFFF_FFFF);
    settle();
    check_levels("R3 unmask all");

    // R5 latency of a request edge
    irq_in = '0;
    settle();
    @(negedge clk);
    irq_in[3] = 1'b1;
    @(negedge clk);
    chk(lvl_irq[3] == 1'b0, "R5 one edge after request", 32'(lvl_irq[3]), 0);
    @(negedge clk);
    chk(lvl_irq[3] == 1'b1, "R5 two edges after request", 32'(lvl_irq[3]), 1);
    // R5 latency of a mask write
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4; bus_wdata = 32'hFFFF_FFF7;
    @(negedge clk);
    bus_wr = 1'b0; m_mask = 32'hFFFF_FFF7;
    chk(lvl_irq[3] == 1'b1, "R5 write edge", 32'(lvl_irq[3]), 1);
    @(negedge clk);
    chk(lvl_irq[3] == 1'b0, "R5 one edge after write", 32'(lvl_irq[3]), 0);
    wr(4, 32'hFFFF_FFFF);

    // R4 lowest index wins: sources 2, 9, 16 all on level 2
    irq_in = (32'h1 << 16) | (32'h1 << 9) | (32'h1 << 2);
    settle();
    check_levels("R4 lowest index");
    irq_in[2] = 1'b0;
    settle();
    check_levels("R4 next lowest");

    // R2 fields 7..15 route nowhere
    wr(0, 32'h00F0_7080);
    irq_in = 32'h0000_00FF;
    settle();
    check_levels("R2 unrouted fields");
    chk(lvl_irq[0] == 1'b1, "R2 field 0 routes to level 0", 32'(lvl_irq[0]), 1);

    // R6 status read and read-only addresses
    irq_in = 32'hA5A5_0F0F;
    settle();
    rdreg(6, rd); chk(rd == irq_in, "R6 status read", rd, irq_in);
    wr(6, 32'h0); wr(7, 32'hFF);
    rdreg(6, rd); chk(rd == irq_in, "R6 status write ignored", rd, irq_in);
    rdreg(7, rd); chk(rd == 0, "R6 count write ignored", rd, 0);

    // R7 wake independent of mask
    wr(4, 32'h0);
    wr(5, 32'h0000_0100);
    settle();
    chk(wake_req == 1'b1, "R7 wake with mask off", 32'(wake_req), 1);
    irq_in[8] = 1'b0;
    settle();
    chk(wake_req == 1'b0, "R7 wake source low", 32'(wake_req), 0);
    wr(5, 32'hFFFF_FFFF);
    settle();
    chk(wake_req == 1'b1, "R7 wake enable all", 32'(wake_req), 1);

    // R8 spurious acknowledges
    wr(4, 32'hFFFF_FFFF);
    irq_in = 32'h0000_0001;
    wr(0, 32'h6543_2100);
    settle();
    ack(3'd0);
    chk(spur_pulse == 1'b0, "R8 ack active level", 32'(spur_pulse), 0);
    ack(3'd5);
    chk(spur_pulse == 1'b1, "R8 ack idle level", 32'(spur_pulse), 1);
    @(negedge clk);
    chk(spur_pulse == 1'b0, "R8 pulse one cycle", 32'(spur_pulse), 0);
    ack(3'd7);
    chk(spur_pulse == 1'b0, "R8 out-of-range level", 32'(spur_pulse), 0);
    rdreg(7, rd); chk(rd == 1, "R8 count step", rd, 1);

    // R9 saturation
    @(negedge clk);
    ack_vld = 1'b1; ack_lvl = 3'd6;
    repeat (300) @(negedge clk);
    ack_vld = 1'b0;
    rdreg(7, rd); chk(rd == 255, "R9 saturated count", rd, 255);

    // random routing, mask and request patterns
    for (int it = 0; it < 40; it++) begin
      for (int w = 0; w < 4; w++) begin
        logic [31:0] x = '0;
        for (int k = 0; k < 8; k++) x[k*4 +: 4] = 4'($urandom_range(0, 9));
        wr(4'(w), x);
      end
      wr(4, $urandom());
      irq_in = $urandom() & $urandom();
      settle();
      check_levels("R4 random");
      if (it % 8 == 0) begin
        int w = it / 8 % 4;
        rdreg(4'(w), rd); chk(rd == exp_word(w), "R1 routing readback", rd, exp_word(w));
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule